// File: doc/BRIEF.md
# Synchronous SRAM Read/Write Datapath Controller

This block is the data side of a synchronous burst SRAM. It holds a small word-organised array split into 8-bit lanes and decodes one command per rising clock edge: deselect, read or write. Writes land in the same edge that carries the command, either on the strobed lanes only or on every lane at once. Reads drive the data bus after a latency picked by a mode input. The data can come straight out of the array (flow-through) or pass through one more output register (pipelined).

A second mode input sets how fast the bus is released after a deselect. In single-cycle mode the release follows the deselect edge at once. In dual-cycle mode the release waits one more edge. Output enable and sleep act without waiting for the clock. Sleep also blocks every command while the stored words stay intact.

The output side is a four-state machine. OUT_OFF means the bus is released. OUT_READ means read data is driven. OUT_HOLD is the one extra cycle in which the last read word stays driven after a flow-through deselect in dual-cycle mode. OUT_ASLEEP is entered on every edge that sees sleep high. Its transitions are:
- OFF/READ/HOLD to READ on a read slot.
- READ to HOLD on a flow-through dual-cycle deselect.
- any state to OFF on a deselect, on a write, or on a single-cycle cut.
- any state to ASLEEP on sleep.
- ASLEEP to OFF or READ on wake.

Top module: `sram_datapath_ctrl`

## Requirements
- R1: Each rising edge captures one command. `cen` low is a deselect. `cen` high with `gwe`, or with `bwe` and at least one strobe set, is a write. Any other `cen` high is a read. A write never drives the bus: `rvalid` is 0 in its output slot.
- R2: With `pipe_mode` low (flow-through), a read captured at edge k drives `rvalid`=1 and the addressed word on `rdata` during the cycle that follows edge k.
- R3: With `pipe_mode` high (pipelined), the same read is driven one edge later, in the cycle after edge k+1. Back-to-back reads give one word per cycle.
- R4: A write with `bwe` high and `gwe` low updates only the lanes whose `bstb` bit is set. Lane i is `wdata[8i+7:8i]`. With no strobe set, the command is a read and nothing is written.
- R5: `gwe` high with `cen` high writes all lanes, whatever `bwe` and `bstb` hold.
- R6: Write data is taken on the same edge as the write command. A read of that address captured on any later edge returns the new bytes.
- R7: With `dual_desel` low, a deselect captured at edge k releases the bus (`rvalid`=0) in the cycle after edge k. In pipelined mode this also cuts a read whose slot would have fallen there.
- R8: With `dual_desel` high in flow-through mode, a deselect that follows a read keeps the read word driven for one more cycle and releases after the next edge. In pipelined mode a deselect is delayed exactly like a read.
- R9: `oe` low forces `rvalid`=0 and `rdata`=0 at once, without a clock edge. Raising `oe` again restores the pending output within the same cycle.
- R10: `sleep` high forces the bus off at once. Every edge that sees it high accepts no command, so writes are ignored. Stored words are kept, and after wake the bus stays off until a new read reaches its slot.
- R11: During and right after reset, `rvalid`=0 and `rdata`=0. Whenever `rvalid` is 0, `rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| cen | input | 1 | Chip enable; low means deselect |
| addr | input | ADDR_W | Word address |
| bwe | input | 1 | Byte write enable |
| gwe | input | 1 | Global write, all lanes |
| bstb | input | BYTES | Per-lane write strobes |
| wdata | input | 8*BYTES | Write data, same cycle as the command |
| oe | input | 1 | Output enable, asynchronous |
| sleep | input | 1 | Low-power request, asynchronous gate |
| pipe_mode | input | 1 | 1 = pipelined output, 0 = flow-through |
| dual_desel | input | 1 | 1 = dual-cycle deselect, 0 = single-cycle |
| rdata | output | 8*BYTES | Read data, zero when not driven |
| rvalid | output | 1 | Bus drive / data valid flag |

## Verification
A flow-through read is due in the cycle right after its capture edge. A pipelined read is due one edge later. A dual-cycle hold adds exactly one cycle, and a single-cycle cut takes effect in the cycle after the deselect edge. The bench drives each command on a falling edge, lets one rising edge pass, and samples on the next falling edge, so every table row checks the slot opened by that row's capture edge. The expected values take the latency of the row one or two entries earlier into account. `oe` and `sleep` are asynchronous, so they are changed between edges and the outputs are sampled 1 ns later, with no clock edge in between.

// File: rtl/sram_dp_pkg.sv
`timescale 1ns/1ps
package sram_dp_pkg;

    // command decoded from the control pins at a rising edge
    typedef enum logic [1:0] {
        CMD_DESEL = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2
    } cmd_e;

    // condition of the read data bus in the current cycle
    typedef enum logic [1:0] {
        OUT_OFF    = 2'd0,
        OUT_READ   = 2'd1,
        OUT_HOLD   = 2'd2,
        OUT_ASLEEP = 2'd3
    } out_st_e;

    localparam int LANE_W = 8;

endpackage

// File: rtl/sram_cmd_decode.sv
`timescale 1ns/1ps
module sram_cmd_decode
    import sram_dp_pkg::*;
#(
    parameter int BYTES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cen,
    input  logic             bwe,
    input  logic             gwe,
    input  logic [BYTES-1:0] bstb,
    input  logic             sleep,
    output cmd_e             cmd,
    output logic [BYTES-1:0] lane_we
);

    logic any_strobe;
    logic wr_req;

    assign any_strobe = |bstb;
    assign wr_req     = gwe | (bwe & any_strobe);

    always_comb begin
        if (sleep || !cen) begin
            cmd = CMD_DESEL;
        end else if (wr_req) begin
            cmd = CMD_WRITE;
        end else begin
            cmd = CMD_READ;
        end
    end

    // per-lane write enables
    for (genvar g = 0; g < BYTES; g++) begin : g_lane_we
        assign lane_we[g] = (cmd == CMD_WRITE) & (gwe | (bwe & bstb[g]));
    end

    AST_SLEEP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> (lane_we == '0)); // R10
    AST_GLOBAL_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (cen && gwe && !sleep) |-> (&lane_we)); // R5
    AST_BYTE_ONLY_STROBED: assert property (@(posedge clk) disable iff (!rst_n)
        (cen && !gwe && bwe && !sleep) |-> (lane_we == bstb)); // R4
    AST_DESEL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !cen |-> (lane_we == '0)); // R1

endmodule

// File: rtl/sram_lane_array.sv
`timescale 1ns/1ps
module sram_lane_array
    import sram_dp_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int BYTES  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [BYTES-1:0]          lane_we,
    input  logic [ADDR_W-1:0]         waddr,
    input  logic [LANE_W*BYTES-1:0]   wdata,
    input  logic [ADDR_W-1:0]         raddr,
    output logic [LANE_W*BYTES-1:0]   rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        logic [LANE_W-1:0] store_q [DEPTH];

        always_ff @(posedge clk) begin
            if (lane_we[g]) begin
                store_q[waddr] <= wdata[g*LANE_W +: LANE_W];
            end
        end

        assign rdata[g*LANE_W +: LANE_W] = store_q[raddr];

        AST_LANE_STORE: assert property (@(posedge clk) disable iff (!rst_n)
            lane_we[g] |=> (store_q[$past(waddr)] == $past(wdata[g*LANE_W +: LANE_W]))); // R6
    end

endmodule

// File: rtl/sram_out_fsm.sv
`timescale 1ns/1ps
module sram_out_fsm
    import sram_dp_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pipe_mode,
    input  logic              dual_desel,
    input  logic              sleep,
    input  logic              oe,
    input  cmd_e              cmd_new,
    input  cmd_e              cmd_q,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);

    out_st_e           st;
    out_st_e           st_nx;
    logic [DATA_W-1:0] data_q;
    logic              cut_now;

    // single-cycle deselect cuts the pending slot
    assign cut_now = (cmd_new == CMD_DESEL) && !dual_desel;

    // next state
    always_comb begin
        st_nx = OUT_OFF;
        if (sleep) begin
            st_nx = OUT_ASLEEP;
        end else if (!pipe_mode) begin
            unique case (cmd_new)
                CMD_READ:  st_nx = OUT_READ;
                CMD_DESEL: st_nx = (dual_desel && st == OUT_READ) ? OUT_HOLD : OUT_OFF;
                default:   st_nx = OUT_OFF;
            endcase
        end else begin
            if (cmd_q == CMD_READ && !cut_now) begin
                st_nx = OUT_READ;
            end
        end
    end

    // state and output data register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= OUT_OFF;
            data_q <= '0;
        end else begin
            st     <= st_nx;
            data_q <= arr_rdata;
        end
    end

    // outputs, gated asynchronously by oe and sleep
    always_comb begin
        rvalid = 1'b0;
        rdata  = '0;
        unique case (st)
            OUT_READ: begin
                rvalid = oe && !sleep;
                if (rvalid) begin
                    rdata = pipe_mode ? data_q : arr_rdata;
                end
            end
            OUT_HOLD: begin
                rvalid = oe && !sleep;
                if (rvalid) begin
                    rdata = data_q;
                end
            end
            default: begin
                rvalid = 1'b0;
                rdata  = '0;
            end
        endcase
    end

    AST_FLOW_READ_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !pipe_mode && cmd_new == CMD_READ) |=> (st == OUT_READ)); // R2
    AST_PIPE_READ_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && pipe_mode && dual_desel && cmd_q == CMD_READ) |=> (st == OUT_READ)); // R3
    AST_SCD_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!dual_desel && cmd_new == CMD_DESEL) |=> (st != OUT_READ && st != OUT_HOLD)); // R7
    AST_DCD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!sleep && !pipe_mode && dual_desel && st == OUT_READ && cmd_new == CMD_DESEL)
        |=> (st == OUT_HOLD)); // R8
    AST_HOLD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st == OUT_HOLD) |=> (st != OUT_HOLD)); // R8
    AST_SLEEP_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> (st == OUT_ASLEEP)); // R10
    AST_OE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> (!rvalid && rdata == '0)); // R9
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rvalid |-> (rdata == '0)); // R11

endmodule

// File: rtl/sram_datapath_ctrl.sv
`timescale 1ns/1ps
module sram_datapath_ctrl
    import sram_dp_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int BYTES  = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cen,
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  bwe,
    input  logic                  gwe,
    input  logic [BYTES-1:0]      bstb,
    input  logic [8*BYTES-1:0]    wdata,
    input  logic                  oe,
    input  logic                  sleep,
    input  logic                  pipe_mode,
    input  logic                  dual_desel,
    output logic [8*BYTES-1:0]    rdata,
    output logic                  rvalid
);

    localparam int DATA_W = LANE_W * BYTES;

    cmd_e              cmd_new;
    cmd_e              cmd_q;
    logic [BYTES-1:0]  lane_we;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] arr_rdata;

    sram_cmd_decode #(.BYTES(BYTES)) u_decode (
        .clk     (clk),
        .rst_n   (rst_n),
        .cen     (cen),
        .bwe     (bwe),
        .gwe     (gwe),
        .bstb    (bstb),
        .sleep   (sleep),
        .cmd     (cmd_new),
        .lane_we (lane_we)
    );

    // input capture stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q  <= CMD_DESEL;
            addr_q <= '0;
        end else begin
            cmd_q  <= cmd_new;
            addr_q <= addr;
        end
    end

    sram_lane_array #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .lane_we (lane_we),
        .waddr   (addr),
        .wdata   (wdata),
        .raddr   (addr_q),
        .rdata   (arr_rdata)
    );

    sram_out_fsm #(.DATA_W(DATA_W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .pipe_mode  (pipe_mode),
        .dual_desel (dual_desel),
        .sleep      (sleep),
        .oe         (oe),
        .cmd_new    (cmd_new),
        .cmd_q      (cmd_q),
        .arr_rdata  (arr_rdata),
        .rdata      (rdata),
        .rvalid     (rvalid)
    );

    AST_CAPTURE_DESEL: assert property (@(posedge clk) disable iff (!rst_n)
        (!cen || sleep) |=> (cmd_q == CMD_DESEL)); // R1

endmodule

// File: tb/tb_sram_datapath_ctrl.sv
`timescale 1ns/1ps
module tb_sram_datapath_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cen = 1'b0;
    logic [5:0]  addr = '0;
    logic        bwe = 1'b0;
    logic        gwe = 1'b0;
    logic [3:0]  bstb = '0;
    logic [31:0] wdata = '0;
    logic        oe = 1'b1;
    logic        sleep = 1'b0;
    logic        pipe_mode = 1'b0;
    logic        dual_desel = 1'b0;
    logic [31:0] rdata;
    logic        rvalid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    sram_datapath_ctrl #(.ADDR_W(6), .BYTES(4)) dut (
        .clk(clk), .rst_n(rst_n), .cen(cen), .addr(addr), .bwe(bwe), .gwe(gwe),
        .bstb(bstb), .wdata(wdata), .oe(oe), .sleep(sleep), .pipe_mode(pipe_mode),
        .dual_desel(dual_desel), .rdata(rdata), .rvalid(rvalid)
    );

    typedef struct packed {
        logic        p;
        logic        d;
        logic        c;
        logic        g;
        logic        b;
        logic [3:0]  s;
        logic [5:0]  a;
        logic [31:0] w;
        logic        ev;
        logic [31:0] ed;
        logic [7:0]  rq;
    } vec_t;

    // p d cen gw bw strobes addr wdata | exp_valid exp_data | req
    localparam vec_t VEC [25] = '{
        '{1'b0,1'b0,1'b1,1'b1,1'b0,4'b0000,6'd1,32'h11223344, 1'b0,32'h0,         8'd1}, // R1 write slot off
        '{1'b0,1'b0,1'b1,1'b1,1'b0,4'b0000,6'd2,32'hAABBCCDD, 1'b0,32'h0,         8'd1}, // R1
        '{1'b0,1'b0,1'b1,1'b0,1'b0,4'b0000,6'd1,32'h0,        1'b1,32'h11223344,  8'd2}, // R2 flow read
        '{1'b0,1'b0,1'b1,1'b0,1'b0,4'b0000,6'd2,32'h0,        1'b1,32'hAABBCCDD,  8'd2}, // R2
        '{1'b0,1'b0,1'b1,1'b0,1'b1,4'b0101,6'd1,32'hFFEEDDCC, 1'b0,32'h0,         8'd4}, // R4 lanes 0,2
        '{1'b0,1'b0,1'b1,1'b0,1'b0,4'b0000,6'd1,32'h0,        1'b1,32'h11EE33CC,  8'd4}, // R4 R6
        '{1'b0,1'b0,1'b0,1'b0,1'b0,4'b0000,6'd0,32'h0,        1'b0,32'h0,         8'd7}, // R7 flow cut
        '{1'b0,1'b0,1'b1,1'b0,1'b1,4'b0000,6'd2,32'h12345678, 1'b1,32'hAABBCCDD,  8'd4}, // R4 no strobe = read
        '{1'b0,1'b0,1'b1,1'b1,1'b1,4'b0001,6'd2,32'h01020304, 1'b0,32'h0,         8'd5}, // R5 global
        '{1'b0,1'b0,1'b1,1'b0,1'b0,4'b0000,6'd2,32'h0,        1'b1,32'h01020304,  8'd5}, // R5
        '{1'b0,1'b1,1'b1,1'b0,1'b0,4'b0000,6'd1,32'h0,        1'b1,32'h11EE33CC,  8'd2}, // R2 dual mode
        '{1'b0,1'b1,1'b0,1'b0,1'b0,4'b0000,6'd0,32'h0,        1'b1,32'h11EE33CC,  8'd8}, // R8 hold
        '{1'b0,1'b1,1'b0,1'b0,1'b0,4'b0000,6'd0,32'h0,        1'b0,32'h0,         8'd8}, // R8 release
        '{1'b1,1'b0,1'b1,1'b0,1'b0,4'b0000,6'd1,32'h0,        1'b0,32'h0,         8'd3}, // R3 not yet
        '{1'b1,1'b0,1'b1,1'b0,1'b0,4'b0000,6'd2,32'h0,        1'b1,32'h11EE33CC,  8'd3}, // R3
        '{1'b1,1'b0,1'b1,1'b0,1'b0,4'b0000,6'd1,32'h0,        1'b1,32'h01020304,  8'd3}, // R3 back to back
        '{1'b1,1'b0,1'b0,1'b0,1'b0,4'b0000,6'd0,32'h0,        1'b0,32'h0,         8'd7}, // R7 pipe cut
        '{1'b1,1'b0,1'b0,1'b0,1'b0,4'b0000,6'd0,32'h0,        1'b0,32'h0,         8'd7}, // R7
        '{1'b1,1'b1,1'b1,1'b0,1'b0,4'b0000,6'd2,32'h0,        1'b0,32'h0,         8'd3}, // R3
        '{1'b1,1'b1,1'b0,1'b0,1'b0,4'b0000,6'd0,32'h0,        1'b1,32'h01020304,  8'd8}, // R8 pipe dual
        '{1'b1,1'b1,1'b0,1'b0,1'b0,4'b0000,6'd0,32'h0,        1'b0,32'h0,         8'd8}, // R8
        '{1'b1,1'b1,1'b1,1'b1,1'b0,4'b0000,6'd3,32'hCAFEF00D, 1'b0,32'h0,         8'd6}, // R6 write
        '{1'b1,1'b1,1'b1,1'b0,1'b0,4'b0000,6'd3,32'h0,        1'b0,32'h0,         8'd6}, // R6 write slot
        '{1'b1,1'b1,1'b0,1'b0,1'b0,4'b0000,6'd0,32'h0,        1'b1,32'hCAFEF00D,  8'd6}, // R6 new data
        '{1'b1,1'b1,1'b0,1'b0,1'b0,4'b0000,6'd0,32'h0,        1'b0,32'h0,         8'd8}  // R8
    };

    task automatic check(input logic ev, input logic [31:0] ed, input string tag);
        checks++;
        if (rvalid !== ev || rdata !== ed) begin
            errors++;
            $display("FAIL %s: rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h",
                     tag, rvalid, rdata, ev, ed);
        end
    endtask

    task automatic put(input logic p, input logic d, input logic c, input logic g,
                       input logic b, input logic [3:0] s, input logic [5:0] a,
                       input logic [31:0] w);
        pipe_mode = p; dual_desel = d; cen = c; gwe = g; bwe = b;
        bstb = s; addr = a; wdata = w;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        #(8 * 20000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run hung, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(1'b0, 32'h0, "R11 in reset");
        rst_n = 1'b1;
        tick();
        check(1'b0, 32'h0, "R11 after reset");

        for (int i = 0; i < 25; i++) begin
            put(VEC[i].p, VEC[i].d, VEC[i].c, VEC[i].g, VEC[i].b, VEC[i].s, VEC[i].a, VEC[i].w);
            tick();
            check(VEC[i].ev, VEC[i].ed, $sformatf("R%0d row %0d", VEC[i].rq, i));
        end

        // R9: output enable, flow single-cycle mode
        put(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0000, 6'd0, 32'h0);
        tick();
        oe = 1'b0;
        put(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'b0000, 6'd1, 32'h0);
        tick();
        check(1'b0, 32'h0, "R9 oe low hides read");
        oe = 1'b1;
        #1;
        check(1'b1, 32'h11EE33CC, "R9 oe restored same cycle");

        // R10: sleep, async gate then ignored write
        sleep = 1'b1;
        #1;
        check(1'b0, 32'h0, "R10 sleep async off");
        @(negedge clk);
        put(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 4'b0000, 6'd1, 32'h00000000);
        tick();
        check(1'b0, 32'h0, "R10 asleep no drive");
        sleep = 1'b0;
        put(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'b0000, 6'd0, 32'h0);
        tick();
        check(1'b0, 32'h0, "R10 off after wake");
        put(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'b0000, 6'd1, 32'h0);
        tick();
        check(1'b1, 32'h11EE33CC, "R10 contents kept, write ignored");

        // R11: idle bus reads as zero after a write
        put(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 4'b1000, 6'd4, 32'h5A000000);
        tick();
        check(1'b0, 32'h0, "R11 idle data zero");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule